// File: doc/BRIEF.md
# In-System Programming Pin Isolation Controller

This block sits inside a device that is programmed over its JTAG port. It watches the instruction captured by the TAP controller and decides how the device's functional pins behave around a programming session. A session opens with an enter opcode. From the next clock the pins stop driving, a weak pull-up is switched on for each of them, and every pad input is masked before it reaches the core. Program, erase and verify opcodes are granted only inside an open session.

A session closes in two steps. The exit opcode only arms the return. The return happens when a later instruction other than enter is loaded. At that point the block emits a one-cycle re-initialise pulse, so user registers take their preset values, and it hands each pin back to its configured direction one cycle later. Loading enter again from the armed state reopens the session without a pulse. A Test-Logic-Reset indication from the TAP ends any session at once, with the same pulse.

Top module: `isp_pin_guard`

## Requirements
- R1: After `rst_n` is released, `mode_o` is 0 (mission), `pin_oe` equals `cfg_oe`, `pin_sense` and `pin_pullup` are all ones and all zeros respectively, `core_in` equals `pin_in`, and `reinit` is 0.
- R2: An `update_ir` strobe that carries `OP_ENTER` in mission mode sets `mode_o` to 1 (session active) from the next cycle. While `mode_o` is non-zero, `pin_oe` is all zeros and `pin_pullup` is all ones.
- R3: While `mode_o` is non-zero, `pin_sense` is all zeros and `core_in` is all zeros, whatever `pin_in` holds.
- R4: `mode_o` changes only on a clock edge where `update_ir` or `tap_reset` is high. A new `ir_value` without a strobe has no effect.
- R5: A strobe with `OP_EXIT` while `mode_o` is 1 sets `mode_o` to 2 (exit armed). The pins stay isolated and no `reinit` pulse is issued.
- R6: A strobe with any opcode other than `OP_ENTER` while `mode_o` is 2 returns `mode_o` to 0 and raises `reinit` for exactly one cycle.
- R7: A strobe with `OP_ENTER` while `mode_o` is 2 returns `mode_o` to 1 with no `reinit` pulse.
- R8: During the `reinit` cycle `pin_oe` is all zeros. From the following cycle `pin_oe` follows `cfg_oe`.
- R9: `tap_reset` high at an edge while `mode_o` is 1 or 2 sets `mode_o` to 0 and pulses `reinit`. It takes priority over a strobe in the same cycle. In mission mode it produces no pulse.
- R10: `mem_op_grant` is high only when `mode_o` is 1 and `ir_value` equals `OP_PROG`, `OP_ERASE` or `OP_VERIFY`.
- R11: In mission mode a strobe with any opcode other than `OP_ENTER`, including `OP_EXIT`, leaves `mode_o` at 0 and issues no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tap_reset | input | 1 | TAP in Test-Logic-Reset (or TRST seen), sampled on clk |
| update_ir | input | 1 | One-cycle strobe: a new instruction has been loaded |
| ir_value | input | IR_W | Current instruction register contents |
| cfg_oe | input | N_PINS | Configured output enables from user logic |
| pin_in | input | N_PINS | Levels seen at the pads |
| pin_oe | output | N_PINS | Output enables to the pad drivers |
| pin_pullup | output | N_PINS | Weak pull-up enables |
| pin_sense | output | N_PINS | Input sensing gate per pin |
| core_in | output | N_PINS | Gated pad levels to the core |
| reinit | output | 1 | One-cycle pulse that reloads user registers |
| mem_op_grant | output | 1 | Program, erase or verify opcode is allowed |
| mode_o | output | 2 | 0 mission, 1 session active, 2 exit armed |

## Verification
Mode changes are registered, so a strobe or TAP reset applied before an edge shows on `mode_o`, the pin controls and `reinit` just after that edge, one cycle later. `pin_oe` returns to `cfg_oe` one cycle after that. `core_in` and `mem_op_grant` also follow the current `pin_in` and `ir_value` within the same cycle. The bench drives each input on the falling edge and checks every output a nanosecond later against a reference model. It then advances the model by the inputs that the coming rising edge will sample. Every comparison therefore sees exactly the registers updated by the previous edge.

// File: rtl/isp_pin_guard.sv
module isp_pin_guard #(
  parameter int N_PINS = 8,
  parameter int IR_W = 8,
  parameter logic [IR_W-1:0] OP_ENTER  = 8'hE8,
  parameter logic [IR_W-1:0] OP_EXIT   = 8'hE9,
  parameter logic [IR_W-1:0] OP_PROG   = 8'hEA,
  parameter logic [IR_W-1:0] OP_ERASE  = 8'hED,
  parameter logic [IR_W-1:0] OP_VERIFY = 8'hEE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tap_reset,
  input  logic              update_ir,
  input  logic [IR_W-1:0]   ir_value,
  input  logic [N_PINS-1:0] cfg_oe,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_oe,
  output logic [N_PINS-1:0] pin_pullup,
  output logic [N_PINS-1:0] pin_sense,
  output logic [N_PINS-1:0] core_in,
  output logic              reinit,
  output logic              mem_op_grant,
  output logic [1:0]        mode_o
);

  typedef enum logic [1:0] {
    MISSION   = 2'd0,
    ISP_ON    = 2'd1,
    EXIT_ARMD = 2'd2
  } mode_t;

  mode_t mode_q, mode_d;
  logic  reinit_q, reinit_d;

  wire is_enter = (ir_value == OP_ENTER);
  wire is_exit  = (ir_value == OP_EXIT);
  wire is_memop = (ir_value == OP_PROG) || (ir_value == OP_ERASE) ||
                  (ir_value == OP_VERIFY);

  always_comb begin
    mode_d   = mode_q;
    reinit_d = 1'b0;
    if (tap_reset) begin
      mode_d   = MISSION;
      reinit_d = (mode_q != MISSION);
    end else if (update_ir) begin
      unique case (mode_q)
        MISSION:   if (is_enter) mode_d = ISP_ON;
        ISP_ON:    if (is_exit)  mode_d = EXIT_ARMD;
        EXIT_ARMD: begin
          if (is_enter) begin
            mode_d = ISP_ON;
          end else begin
            mode_d   = MISSION;
            reinit_d = 1'b1;
          end
        end
        default: mode_d = MISSION;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MISSION;
      reinit_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      reinit_q <= reinit_d;
    end
  end

  wire isolated = (mode_q != MISSION);
  wire drive_ok = !isolated && !reinit_q;

  assign pin_oe       = drive_ok ? cfg_oe : '0;
  assign pin_pullup   = {N_PINS{isolated}};
  assign pin_sense    = {N_PINS{!isolated}};
  assign core_in      = pin_in & pin_sense;
  assign reinit       = reinit_q;
  assign mem_op_grant = (mode_q == ISP_ON) && is_memop;
  assign mode_o       = mode_q;

endmodule

// File: rtl/isp_pin_guard_chk.sv
module isp_pin_guard_chk #(
  parameter int N_PINS = 8,
  parameter int IR_W = 8,
  parameter logic [IR_W-1:0] OP_ENTER = 8'hE8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tap_reset,
  input logic              update_ir,
  input logic [IR_W-1:0]   ir_value,
  input logic [N_PINS-1:0] pin_oe,
  input logic [N_PINS-1:0] pin_pullup,
  input logic [N_PINS-1:0] core_in,
  input logic              reinit,
  input logic              mem_op_grant,
  input logic [1:0]        mode_o
);

  a_r2_isolated_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'd0) |-> (pin_oe == '0 && pin_pullup == '1));

  a_r3_inputs_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'd0) |-> (core_in == '0));

  a_r4_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!update_ir && !tap_reset) |=> $stable(mode_o));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> !reinit);

  a_r6_pulse_in_mission: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |-> (mode_o == 2'd0));

  a_r7_reenter_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2 && update_ir && !tap_reset && ir_value == OP_ENTER)
      |=> (mode_o == 2'd1 && !reinit));

  a_r8_oe_off_on_reinit: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |-> (pin_oe == '0));

  a_r9_tap_reset_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_reset && mode_o != 2'd0) |=> (mode_o == 2'd0 && reinit));

  a_r10_grant_in_session: assert property (@(posedge clk) disable iff (!rst_n)
    mem_op_grant |-> (mode_o == 2'd1));

endmodule

bind isp_pin_guard isp_pin_guard_chk #(
  .N_PINS(N_PINS), .IR_W(IR_W), .OP_ENTER(OP_ENTER)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tap_reset(tap_reset), .update_ir(update_ir),
  .ir_value(ir_value), .pin_oe(pin_oe), .pin_pullup(pin_pullup),
  .core_in(core_in), .reinit(reinit), .mem_op_grant(mem_op_grant),
  .mode_o(mode_o)
);

// File: tb/isp_pin_guard_test.sv
`timescale 1ns/1ps
module isp_pin_guard_test;
  localparam int N = 8;
  localparam logic [7:0] ENT = 8'hE8, EXT = 8'hE9, PRG = 8'hEA,
                         ERS = 8'hED, VFY = 8'hEE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tap_reset = 1'b0, update_ir = 1'b0;
  logic [7:0] ir_value = 8'h00;
  logic [N-1:0] cfg_oe = '0, pin_in = '0;
  logic [N-1:0] pin_oe, pin_pullup, pin_sense, core_in;
  logic reinit, mem_op_grant;
  logic [1:0] mode_o;

  int checks = 0, errors = 0;
  logic [1:0] m_mode = 2'd0;
  logic m_reinit = 1'b0;

  always #2 clk = ~clk;

  isp_pin_guard uut (
    .clk(clk), .rst_n(rst_n), .tap_reset(tap_reset), .update_ir(update_ir),
    .ir_value(ir_value), .cfg_oe(cfg_oe), .pin_in(pin_in), .pin_oe(pin_oe),
    .pin_pullup(pin_pullup), .pin_sense(pin_sense), .core_in(core_in),
    .reinit(reinit), .mem_op_grant(mem_op_grant), .mode_o(mode_o)
  );

  function automatic logic is_mem(input logic [7:0] op);
    return op == PRG || op == ERS || op == VFY;
  endfunction

  function automatic logic [N-1:0] exp_oe(input logic [1:0] md, input logic ri,
                                          input logic [N-1:0] cfg);
    return (md == 2'd0 && !ri) ? cfg : '0;
  endfunction

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic iso;
    iso = (m_mode != 2'd0);
    cmp(tag, "mode_o", 32'(mode_o), 32'(m_mode));
    cmp(tag, "reinit", 32'(reinit), 32'(m_reinit));
    cmp(tag, "pin_oe", 32'(pin_oe), 32'(exp_oe(m_mode, m_reinit, cfg_oe)));
    cmp(tag, "pin_pullup", 32'(pin_pullup), 32'({N{iso}}));
    cmp(tag, "pin_sense", 32'(pin_sense), 32'({N{!iso}}));
    cmp(tag, "core_in", 32'(core_in), 32'(iso ? '0 : pin_in));
    cmp(tag, "mem_op_grant", 32'(mem_op_grant),
        32'(m_mode == 2'd1 && is_mem(ir_value)));
  endtask

  task automatic model_step();
    logic [1:0] nm;
    logic nr;
    nm = m_mode;
    nr = 1'b0;
    if (tap_reset) begin
      nr = (m_mode != 2'd0);
      nm = 2'd0;
    end else if (update_ir) begin
      case (m_mode)
        2'd0: if (ir_value == ENT) nm = 2'd1;
        2'd1: if (ir_value == EXT) nm = 2'd2;
        default: begin
          if (ir_value == ENT) nm = 2'd1;
          else begin nm = 2'd0; nr = 1'b1; end
        end
      endcase
    end
    m_mode = nm;
    m_reinit = nr;
  endtask

  task automatic cyc(input logic [7:0] op, input logic upd, input logic tr,
                     input string tag);
    @(negedge clk);
    ir_value = op;
    update_ir = upd;
    tap_reset = tr;
    cfg_oe = N'($urandom);
    pin_in = N'($urandom);
    #1 check_all(tag);
    model_step();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd12345));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cfg_oe = 8'hA5;
    pin_in = 8'h3C;
    #1 check_all("R1");
    // R11: exit and other opcodes in mission mode
    cyc(EXT, 1, 0, "R1");
    cyc(PRG, 1, 0, "R11");
    cyc(ENT, 0, 0, "R11");
    // R4: new ir without strobe
    cyc(ENT, 1, 0, "R4");
    // R2 / R3: session active, pins isolated
    cyc(PRG, 0, 0, "R2");
    cyc(ERS, 1, 0, "R10");
    cyc(VFY, 0, 0, "R3");
    cyc(EXT, 1, 0, "R10");
    // R5: exit armed
    cyc(EXT, 0, 0, "R5");
    // R7: re-enter
    cyc(ENT, 1, 0, "R5");
    cyc(EXT, 1, 0, "R7");
    cyc(8'h11, 1, 0, "R5");
    // R6 / R8: leave with pulse, oe back one cycle later
    cyc(8'h11, 0, 0, "R6");
    cyc(8'h11, 0, 0, "R8");
    // R9: TAP reset beats strobe
    cyc(ENT, 1, 0, "R8");
    cyc(EXT, 1, 1, "R2");
    cyc(8'h00, 0, 0, "R9");
    cyc(8'h00, 0, 1, "R9");
    cyc(8'h00, 0, 0, "R9");
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] op;
      case ($urandom_range(0, 6))
        0, 1: op = ENT;
        2: op = EXT;
        3: op = PRG;
        4: op = ERS;
        5: op = VFY;
        default: op = 8'($urandom);
      endcase
      cyc(op, ($urandom_range(0, 9) < 4), ($urandom_range(0, 29) == 0), "R6");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule